// File: doc/BRIEF.md
# SPI Master Controller with Word-Mapped Registers

This block is a serial peripheral interface master that software drives through three 32-bit words on a simple register bus. One configuration word holds every control: the frame length, the idle clock level, the clock divider, the chip-select choice and a start bit. The same word also reports a busy flag. The second word, the transmit word, holds the outgoing frame aligned to its top bit. The third word, the receive word, collects the incoming bits at its bottom end.

To run a transfer, software writes the frame into the transmit word and writes the configuration word with the start bit set. The block then lowers the chosen chip-select line and toggles the serial clock at a rate derived from the divider. On every bit it sends one bit on the output data line and samples one bit from the input data line. When the frame is complete it releases the chip-select line, clears start and busy, and leaves the received frame right-aligned in the receive word. A bus write that arrives while a frame is running is dropped.

Word indices on `bus_addr`: 0 is the configuration word, 1 is the receive word, 2 is the transmit word, and 3 reads as zero.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the configuration, receive and transmit words read 0, index 3 reads 0, all `cs_n` lines are 1 and `sclk` is 0.
- R2: A write to index 0 with bit 0 set while idle makes bit 31 (busy) read 1 from the next cycle on. The same write with bit 0 clear starts nothing.
- R3: With divider field N in bits 9:4, each half period of `sclk` lasts 2*(N+1) bus cycles. Busy stays high for (2*L+1)*2*(N+1) cycles, where L is the effective frame length.
- R4: Bit 1 sets the idle level of `sclk`. The first edge of each bit leaves that level, and exactly L such edges occur per frame.
- R5: The transmit word is sent most significant bit first, starting at bit 31, so the slave receives its top L bits. After the frame the transmit word has moved left by L places, with 1s filled in at the bottom.
- R6: `miso` is sampled on the first edge of each bit and shifted into bit 0 of the receive word. After the frame, the low L bits of that word hold the received frame, with the first bit received at position L-1.
- R7: The length field in bits 22:16 reads back as written. The effective length L is that value limited to the range 4 to 32.
- R8: The chip-select index in bits 24:23 selects the line `cs_n[index]`. That line is low for the whole busy period and every other line stays high. All lines are high while idle.
- R9: When the frame completes, bit 0 (start) and bit 31 (busy) read 0. Bits 1 to 3 and the divider, length and index fields keep the values written.
- R10: While busy, bus writes to any index are ignored. Neither the configuration fields nor the transmit word change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip-select lines |

## Verification
The hardest case to reach from the ports is a bus write that lands in the middle of a running frame. Such a write must leave both the transmit shift and the configuration untouched. To reach it, the stimulus issues two writes straight after the start write, one to the transmit word and one to the configuration word, each with different values. It then checks that the serial output, the busy length and the final shifted transmit word all match the original frame. A bit-level slave model in the bench captures `mosi` and feeds `miso` on the clock edges, and this is what lets the frame contents be compared across both polarities and the length limits.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W   = 32;
  localparam int DIV_W    = 6;
  localparam int LEN_W    = 7;
  localparam int CNT_W    = DIV_W + 2;
  localparam int BITS_W   = $clog2(WORD_W) + 1;
  localparam int MIN_LEN  = 4;

  localparam int F_START  = 0;
  localparam int F_POL    = 1;
  localparam int F_MODE   = 2;
  localparam int F_RDFLG  = 3;
  localparam int F_DIV_LO = 4;
  localparam int F_LEN_LO = 16;
  localparam int F_CS_LO  = 23;
  localparam int F_BUSY   = 31;

  localparam logic [1:0] A_CFG = 2'd0;
  localparam logic [1:0] A_RX  = 2'd1;
  localparam logic [1:0] A_TX  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} spim_state_e;

  // bus cycles in one half period of the serial clock
  function automatic logic [CNT_W-1:0] half_cycles(input logic [DIV_W-1:0] div);
    return CNT_W'(({2'b00, div} + CNT_W'(1)) << 1);
  endfunction

  // effective frame length: the written field limited to MIN_LEN..WORD_W
  function automatic logic [BITS_W-1:0] frame_bits(input logic [LEN_W-1:0] fld);
    if (fld < LEN_W'(MIN_LEN)) return BITS_W'(MIN_LEN);
    if (fld > LEN_W'(WORD_W))  return BITS_W'(WORD_W);
    return fld[BITS_W-1:0];
  endfunction
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv
  import spim_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  localparam int CW = DW + 2;

  logic [CW-1:0] cnt;
  logic [CW-1:0] half;

  assign half = CW'(half_cycles(DIV_W'(div)));
  assign tick = run && (cnt == half - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + CW'(1);
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_tx,
  input  logic         wr_rx,
  input  logic [W-1:0] wdata,
  input  logic         shift_out,
  input  logic         sample_in,
  input  logic         miso,
  output logic [W-1:0] tx_word,
  output logic [W-1:0] rx_word,
  output logic         mosi
);
  assign mosi = tx_word[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_word <= '0;
    else if (wr_tx)      tx_word <= wdata;
    else if (shift_out)  tx_word <= {tx_word[W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rx_word <= '0;
    else if (wr_rx)      rx_word <= wdata;
    else if (sample_in)  rx_word <= {rx_word[W-2:0], miso};
  end

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_out && sample_in));
  assert_fill_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_out && !wr_tx) |=> tx_word[0]);
  assert_rx_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_in && !wr_rx) |=> rx_word[0] == $past(miso));
endmodule

// File: rtl/spim_csdec.sv
module spim_csdec #(
  parameter int NUM_CS = 4,
  localparam int IW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [IW-1:0]     sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = !(active && (sel == IW'(i)));
  end

  assert_one_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (&cs_n));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IW = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  spim_state_e       state;
  logic              start_q, pol_q, mode_q, rdflg_q;
  logic [DIV_W-1:0]  div_q;
  logic [LEN_W-1:0]  len_q;
  logic [IW-1:0]     cs_q;
  logic [BITS_W-1:0] bits_left;
  logic              second_half;
  logic              sclk_q;

  logic              busy, tick, shift_ev, sample_ev;
  logic              cfg_wr, tx_wr, rx_wr, launch;
  logic [WORD_W-1:0] tx_word, rx_word, cfg_word;

  assign busy      = (state != ST_IDLE);
  assign cfg_wr    = bus_wr && (bus_addr == A_CFG) && !busy;
  assign tx_wr     = bus_wr && (bus_addr == A_TX)  && !busy;
  assign rx_wr     = bus_wr && (bus_addr == A_RX)  && !busy;
  assign launch    = cfg_wr && bus_wdata[F_START];
  assign sample_ev = tick && ((state == ST_LEAD) || (state == ST_XFER && !second_half));
  assign shift_ev  = tick && (state == ST_XFER) && second_half;
  assign sclk      = sclk_q;

  spim_clkdiv #(.DW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  spim_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .wr_tx(tx_wr), .wr_rx(rx_wr), .wdata(bus_wdata),
    .shift_out(shift_ev), .sample_in(sample_ev), .miso(miso),
    .tx_word(tx_word), .rx_word(rx_word), .mosi(mosi)
  );

  spim_csdec #(.NUM_CS(NUM_CS)) u_cs (
    .clk(clk), .rst_n(rst_n), .active(busy), .sel(cs_q), .cs_n(cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      start_q     <= 1'b0;
      pol_q       <= 1'b0;
      mode_q      <= 1'b0;
      rdflg_q     <= 1'b0;
      div_q       <= '0;
      len_q       <= '0;
      cs_q        <= '0;
      bits_left   <= '0;
      second_half <= 1'b0;
      sclk_q      <= 1'b0;
    end else if (cfg_wr) begin
      pol_q   <= bus_wdata[F_POL];
      mode_q  <= bus_wdata[F_MODE];
      rdflg_q <= bus_wdata[F_RDFLG];
      div_q   <= bus_wdata[F_DIV_LO +: DIV_W];
      len_q   <= bus_wdata[F_LEN_LO +: LEN_W];
      cs_q    <= bus_wdata[F_CS_LO +: IW];
      sclk_q  <= bus_wdata[F_POL];
      if (launch) begin
        start_q     <= 1'b1;
        state       <= ST_LEAD;
        bits_left   <= frame_bits(bus_wdata[F_LEN_LO +: LEN_W]);
        second_half <= 1'b0;
      end
    end else if (tick) begin
      case (state)
        ST_LEAD: begin
          sclk_q      <= !pol_q;
          second_half <= 1'b1;
          state       <= ST_XFER;
        end
        ST_XFER: begin
          if (second_half) begin
            sclk_q      <= pol_q;
            second_half <= 1'b0;
            if (bits_left == BITS_W'(1)) state <= ST_TRAIL;
            else bits_left <= bits_left - BITS_W'(1);
          end else begin
            sclk_q      <= !pol_q;
            second_half <= 1'b1;
          end
        end
        ST_TRAIL: begin
          state   <= ST_IDLE;
          start_q <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[F_BUSY]              = busy;
    cfg_word[F_START]             = start_q;
    cfg_word[F_POL]               = pol_q;
    cfg_word[F_MODE]              = mode_q;
    cfg_word[F_RDFLG]             = rdflg_q;
    cfg_word[F_DIV_LO +: DIV_W]   = div_q;
    cfg_word[F_LEN_LO +: LEN_W]   = len_q;
    cfg_word[F_CS_LO +: IW]       = cs_q;
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_word;
      A_RX:    bus_rdata = rx_word;
      A_TX:    bus_rdata = tx_word;
      default: bus_rdata = '0;
    endcase
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CFG && bus_wdata[F_START] && !busy) |=> busy);
  assert_no_start_no_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(bus_wr && bus_addr == A_CFG && bus_wdata[F_START])) |=> !busy);
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == pol_q));
  assert_bits_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left >= BITS_W'(1) && bits_left <= BITS_W'(WORD_W)));
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !start_q);
  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr) |=> $stable({pol_q, mode_q, rdflg_q, div_q, len_q, cs_q}));
endmodule

// File: tb/tb_spim_ctrl.sv
module tb_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  cs_n;

  int n_checks = 0;
  int n_fail = 0;
  int cycle = 0;

  always #10 clk = !clk;

  spim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  // slave model: counters are written only here
  logic        armed = 1'b0;
  logic        cur_pol = 1'b0;
  logic [31:0] slv_word = '0;
  int          slv_len = 4;
  logic [31:0] cap = '0;
  int          first_edges = 0;
  int          second_edges = 0;
  int          base_first = 0;
  int          base_second = 0;

  always @(sclk) begin
    if (armed) begin
      if (sclk !== cur_pol) begin
        cap = {cap[30:0], mosi};
        first_edges = first_edges + 1;
      end else begin
        second_edges = second_edges + 1;
      end
    end
  end

  int miso_idx;
  always_comb begin
    miso_idx = slv_len - 1 - (second_edges - base_second);
    miso = (miso_idx >= 0 && miso_idx < 32) ? slv_word[miso_idx] : 1'b0;
  end

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (cycle > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input bit go, input bit pol, input bit md, input bit rf,
                                         input int dv, input int ln, input int cs);
    logic [31:0] w;
    w = 32'(go) | (32'(pol) << 1) | (32'(md) << 2) | (32'(rf) << 3);
    w = w | ((32'(dv) & 32'h3F) << 4) | ((32'(ln) & 32'h7F) << 16) | ((32'(cs) & 32'h3) << 23);
    return w;
  endfunction

  function automatic int eff_len(input int f);
    if (f < 4) return 4;
    if (f > 32) return 32;
    return f;
  endfunction

  // one full frame; poke adds two writes during busy that must be ignored (R10)
  task automatic run_frame(input int lf, input int dv, input bit pol, input int cs,
                           input logic [31:0] tx, input logic [31:0] slv, input bit poke);
    int L, cycles, exp_cycles;
    logic [31:0] rd, exp_mask, exp_tx;
    logic [63:0] wide;
    bit cs_ok;
    L = eff_len(lf);
    exp_mask = (L == 32) ? 32'hFFFF_FFFF : ((32'h1 << L) - 32'h1);
    wide = {tx, 32'hFFFF_FFFF} << L;
    exp_tx = wide[63:32];
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_write(2'd2, tx);
    bus_write(2'd0, mk_cfg(1'b0, pol, 1'b0, 1'b1, dv, lf, cs));
    check(sclk == pol, "R4 idle level", 64'(sclk), 64'(pol));
    cur_pol = pol;
    slv_word = slv;
    slv_len = L;
    base_first = first_edges;
    base_second = second_edges;
    #1;
    armed = 1'b1;
    bus_write(2'd0, mk_cfg(1'b1, pol, 1'b0, 1'b1, dv, lf, cs));
    bus_read(2'd0, rd);
    check(rd[31] == 1'b1, "R2 busy after start", 64'(rd[31]), 64'd1);
    cycles = 0;
    cs_ok = 1'b1;
    if (poke) begin
      bus_write(2'd2, 32'h0000_0000);
      bus_write(2'd0, mk_cfg(1'b1, !pol, 1'b1, 1'b0, 5, 9, cs + 1));
      cycles = 2;
    end
    while (dut.busy === 1'b1 || cs_n !== 4'hF) begin
      if (cs_n !== ~(4'b0001 << cs)) cs_ok = 1'b0;
      cycles = cycles + 1;
      @(negedge clk);
    end
    armed = 1'b0;
    exp_cycles = (2 * L + 1) * 2 * (dv + 1);
    check(cycles == exp_cycles, "R3 busy length", 64'(cycles), 64'(exp_cycles));
    check(cs_ok, "R8 chip select during frame", 64'(cs_n), 64'(~(4'b0001 << cs)));
    check(cs_n == 4'hF, "R8 all high after frame", 64'(cs_n), 64'hF);
    check((first_edges - base_first) == L, "R4 first-edge count", 64'(first_edges - base_first), 64'(L));
    check(sclk == pol, "R4 idle level after frame", 64'(sclk), 64'(pol));
    check((cap & exp_mask) == (tx >> (32 - L)), "R5 MSB-first output",
          64'(cap & exp_mask), 64'(tx >> (32 - L)));
    bus_read(2'd2, rd);
    check(rd == exp_tx, poke ? "R10 tx write ignored" : "R5 tx word shifted", 64'(rd), 64'(exp_tx));
    bus_read(2'd1, rd);
    check((rd & exp_mask) == (slv & exp_mask), "R6 received frame", 64'(rd & exp_mask), 64'(slv & exp_mask));
    bus_read(2'd0, rd);
    check(rd == mk_cfg(1'b0, pol, 1'b0, 1'b1, dv, lf, cs),
          poke ? "R10 cfg write ignored" : "R9 start cleared fields kept",
          64'(rd), 64'(mk_cfg(1'b0, pol, 1'b0, 1'b1, dv, lf, cs)));
  endtask

  // {len7, div6, pol1, cs2, tx32, slave32}
  localparam int NV = 6;
  localparam logic [79:0] VEC [NV] = '{
    {7'd8,  6'd0, 1'b0, 2'd0, 32'hA5FF_FFFF, 32'h0000_003C},
    {7'd16, 6'd1, 1'b1, 2'd1, 32'h1234_FFFF, 32'h0000_BEEF},
    {7'd32, 6'd0, 1'b0, 2'd2, 32'hDEAD_BEEF, 32'h8000_0001},
    {7'd4,  6'd2, 1'b1, 2'd3, 32'h9FFF_FFFF, 32'h0000_0006},
    {7'd12, 6'd3, 1'b0, 2'd1, 32'hABCF_FFFF, 32'h0000_05A5},
    {7'd32, 6'd1, 1'b1, 2'd0, 32'h0F0F_1234, 32'hFFFF_0000}
  };

  initial begin
    logic [31:0] rd;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(cs_n == 4'hF, "R1 cs lines", 64'(cs_n), 64'hF);
    check(sclk == 1'b0, "R1 sclk", 64'(sclk), 64'd0);
    bus_read(2'd0, rd); check(rd == 32'd0, "R1 cfg word", 64'(rd), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd1, rd); check(rd == 32'd0, "R1 rx word", 64'(rd), 64'd0);
    bus_read(2'd2, rd); check(rd == 32'd0, "R1 tx word", 64'(rd), 64'd0);
    bus_read(2'd3, rd); check(rd == 32'd0, "R1 index 3", 64'(rd), 64'd0);

    // R2 no start bit: nothing launches
    bus_write(2'd0, mk_cfg(1'b0, 1'b1, 1'b1, 1'b1, 7, 20, 2));
    @(negedge clk);
    bus_read(2'd0, rd);
    check(rd == mk_cfg(1'b0, 1'b1, 1'b1, 1'b1, 7, 20, 2), "R2 no launch without start",
          64'(rd), 64'(mk_cfg(1'b0, 1'b1, 1'b1, 1'b1, 7, 20, 2)));
    check(cs_n == 4'hF, "R2 cs idle without start", 64'(cs_n), 64'hF);

    for (int i = 0; i < NV; i++) begin
      run_frame(int'(VEC[i][79:73]), int'(VEC[i][72:67]), VEC[i][66], int'(VEC[i][65:64]),
                VEC[i][63:32], VEC[i][31:0], 1'b0);
    end

    // R7 length limits: below 4 acts as 4, above 32 acts as 32
    run_frame(2, 0, 1'b0, 2, 32'hC000_0000, 32'h0000_0009, 1'b0);
    run_frame(100, 0, 1'b1, 3, 32'h5555_AAAA, 32'h1357_9BDF, 1'b0);
    // R10 writes during busy ignored
    run_frame(10, 1, 1'b0, 1, 32'hE7C0_0000, 32'h0000_02D3, 1'b1);
    // R6 large divider, short frame
    run_frame(4, 63, 1'b0, 0, 32'h3000_0000, 32'h0000_000A, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule